// File: doc/BRIEF.md
# Framed Receiver Host Register Port

This block is the processor-facing side of a framed serial receiver. It sits between the receiver's word output and a byte-wide I/O bus. The bus has an 8-bit address, a bidirectional 8-bit data path, and separate active-low read and write strobes. The block holds two registers. The first is a sync-pattern register that the processor loads and reads back. Its value is also sent to the frame detector on `sync_pattern`. The second is a holding register that captures each finished word from the receiver. A full flag records whether that word has been collected yet.

The two bus strobes are asynchronous to the system clock, so each one passes through a two-flop synchronizer first. Edges are then detected on the synchronized level. A write commits when the write strobe is seen to assert. A read is treated as complete when the read strobe is seen to deassert, and the full flag clears at that point. The bus is driven with combinational read data for as long as the read strobe is low on a decoded address.

When a new word arrives while the holding register is still full, the new word replaces the old one. When the processor reads the data address while the holding register is empty, it gets the sync pattern back instead of an old word.

Top module: `rx_host_regs`

## Requirements
- R1: After synchronous reset, the sync-pattern register holds 00h and the holding register is empty. A read of address 01h therefore returns 00h.
- R2: A write strobe with address 00h loads the bus byte into the sync-pattern register. The new value appears on `sync_pattern`.
- R3: A read with address 00h drives the current sync-pattern register value onto the bus.
- R4: A one-cycle `rx_word_vld` pulse loads `rx_word` into the holding register and marks it full. A following read of address 01h returns that word.
- R5: A word that arrives while the holding register is full overwrites the stored word. The register stays full.
- R6: A read of address 01h while the holding register is empty returns the sync-pattern register value.
- R7: The full flag clears on the third rising clock edge after the read strobe returns high, provided the address is 01h at that edge. A read of address 00h leaves the flag unchanged.
- R8: If a word pulse arrives in the same cycle that a read of address 01h is detected as complete, the new word is stored and the flag stays full.
- R9: `io_data` is driven only while `io_rd_n` is low and the address is 00h or 01h. At any other address the bus is left free for other devices.
- R10: A write to address 01h, or a write to any address other than 00h, changes neither register.
- R11: A write takes effect on the third rising clock edge after `io_wr_n` falls. Before that edge, `sync_pattern` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O port address |
| io_data | inout | 8 | Bidirectional I/O data bus |
| io_wr_n | input | 1 | I/O write strobe, active low, asynchronous |
| io_rd_n | input | 1 | I/O read strobe, active low, asynchronous |
| rx_word_vld | input | 1 | One-cycle pulse marking a completed received word |
| rx_word | input | 8 | Received word, valid with `rx_word_vld` |
| sync_pattern | output | 8 | Current sync-pattern register value for the frame detector |

## Verification
Two events can land in the same clock cycle: a word arriving from the receiver, and the synchronized end of a processor read of address 01h. The bench sets up this collision on purpose. It releases the read strobe and then places the word pulse exactly on the clock edge where the release becomes visible. It then checks that the following read returns the new word, not the sync pattern, and that a second read finds the register empty. A behavioural model tracks the sync value, the held word and the full flag, and updates them at the edges worked out from the strobe latency. Every clock cycle, the model is compared with `sync_pattern` and with any bus read in progress.

// File: rtl/rx_host_pkg.sv
package rx_host_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] SYNC_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 8'h01;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SYNC = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             full;
        logic [BUS_W-1:0] data;
    } hold_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        if (a == SYNC_ADDR)      return SEL_SYNC;
        else if (a == DATA_ADDR) return SEL_DATA;
        else                     return SEL_NONE;
    endfunction

endpackage

// File: rtl/rx_host_strobe_sync.sv
module rx_host_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic lvl_n,
    output logic lvl_prev_n
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= strb_n;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_prev_n <= 1'b1;
        else     lvl_prev_n <= chain[LAST];
    end

    assign lvl_n = chain[LAST];

endmodule

// File: rtl/rx_host_sync_reg.sv
module rx_host_sync_reg
    import rx_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_evt,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)                            value <= '0;
        else if (wr_evt && sel == SEL_SYNC) value <= wdata;
    end
endmodule

// File: rtl/rx_host_hold_reg.sv
module rx_host_hold_reg
    import rx_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             word_vld,
    input  logic [BUS_W-1:0] word,
    input  logic             rd_done,
    input  reg_sel_e         sel,
    output hold_t            state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state.full <= 1'b0;
            state.data <= '0;
        end else if (word_vld) begin
            state.full <= 1'b1;
            state.data <= word;
        end else if (rd_done && sel == SEL_DATA) begin
            state.full <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_host_regs.sv
module rx_host_regs
    import rx_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    inout  wire  [BUS_W-1:0]  io_data,
    input  logic              io_wr_n,
    input  logic              io_rd_n,
    input  logic              rx_word_vld,
    input  logic [BUS_W-1:0]  rx_word,
    output logic [BUS_W-1:0]  sync_pattern
);
    logic             wr_lvl_n, wr_prev_n, rd_lvl_n, rd_prev_n;
    logic             wr_fall, rd_rise;
    reg_sel_e         sel;
    logic [BUS_W-1:0] sync_q;
    hold_t            hold_s;
    logic             full_q;
    logic [BUS_W-1:0] hold_q;
    logic             bus_oe;
    logic [BUS_W-1:0] bus_val;

    rx_host_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strb_n(io_wr_n),
        .lvl_n(wr_lvl_n), .lvl_prev_n(wr_prev_n)
    );

    rx_host_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strb_n(io_rd_n),
        .lvl_n(rd_lvl_n), .lvl_prev_n(rd_prev_n)
    );

    assign wr_fall = wr_prev_n & ~wr_lvl_n;
    assign rd_rise = ~rd_prev_n & rd_lvl_n;
    assign sel     = decode_sel(io_addr);

    rx_host_sync_reg u_sync (
        .clk(clk), .rst(rst), .wr_evt(wr_fall), .sel(sel),
        .wdata(io_data), .value(sync_q)
    );

    rx_host_hold_reg u_hold (
        .clk(clk), .rst(rst), .word_vld(rx_word_vld), .word(rx_word),
        .rd_done(rd_rise), .sel(sel), .state(hold_s)
    );

    assign full_q = hold_s.full;
    assign hold_q = hold_s.data;

    always_comb begin
        unique case (sel)
            SEL_SYNC: bus_val = sync_q;
            SEL_DATA: bus_val = full_q ? hold_q : sync_q;
            default:  bus_val = sync_q;
        endcase
    end

    assign bus_oe       = ~io_rd_n && (sel != SEL_NONE);
    assign io_data      = bus_oe ? bus_val : {BUS_W{1'bz}};
    assign sync_pattern = sync_q;

endmodule

// File: rtl/rx_host_regs_chk.sv
module rx_host_regs_chk
    import rx_host_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              io_rd_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [BUS_W-1:0]  io_data,
    input logic              word_vld,
    input logic [BUS_W-1:0]  word,
    input logic              full,
    input logic [BUS_W-1:0]  hold,
    input logic [BUS_W-1:0]  sync_q,
    input logic              wr_fall,
    input logic              rd_rise
);
    // R1: reset empties the holding register and clears the pattern
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!full && sync_q == '0));

    // R4 / R5: a word pulse always loads and marks full
    a_r4_word_loads: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> (full && hold == $past(word)));

    // R8: a word pulse beats a read completion in the same cycle
    a_r8_word_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (word_vld && rd_rise) |=> full);

    // R7: completing a data-address read empties the register
    a_r7_read_end_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && io_addr == DATA_ADDR && !word_vld) |=> !full);

    // R10: the pattern only moves on a write to the sync address
    a_r10_sync_guarded: assert property (@(posedge clk) disable iff (rst)
        !(wr_fall && io_addr == SYNC_ADDR) |=> $stable(sync_q));

    // R6: empty data reads return the pattern
    a_r6_empty_reads_sync: assert property (@(posedge clk) disable iff (rst)
        (!full && !io_rd_n && io_addr == DATA_ADDR) |-> io_data == sync_q);

    // R3: sync-address reads return the pattern
    a_r3_sync_readback: assert property (@(posedge clk) disable iff (rst)
        (!io_rd_n && io_addr == SYNC_ADDR) |-> io_data == sync_q);
endmodule

bind rx_host_regs rx_host_regs_chk u_chk (
    .clk(clk), .rst(rst), .io_rd_n(io_rd_n), .io_addr(io_addr),
    .io_data(io_data), .word_vld(rx_word_vld), .word(rx_word),
    .full(full_q), .hold(hold_q), .sync_q(sync_q),
    .wr_fall(wr_fall), .rd_rise(rd_rise)
);

// File: tb/rx_host_regs_bench.sv
module rx_host_regs_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = 8'hFF;
    logic       io_wr_n = 1'b1;
    logic       io_rd_n = 1'b1;
    logic       rx_word_vld = 1'b0;
    logic [7:0] rx_word = 8'h00;
    logic [7:0] sync_pattern;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_dat = 8'h00;
    wire  [7:0] bus;

    assign bus = tb_oe ? tb_dat : 8'hzz;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_sync = 8'h00;
    logic [7:0] m_hold = 8'h00;
    bit         m_full = 0;

    always #2 clk = ~clk;

    rx_host_regs u_rx_host_regs (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_data(bus),
        .io_wr_n(io_wr_n), .io_rd_n(io_rd_n), .rx_word_vld(rx_word_vld),
        .rx_word(rx_word), .sync_pattern(sync_pattern)
    );

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return m_sync;
        return m_full ? m_hold : m_sync;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(sync_pattern == m_sync, "R2 pattern", sync_pattern, m_sync);
            if (!io_rd_n && !tb_oe && io_addr <= 8'h01)
                chk(bus == model_read(io_addr), "R3 R6 bus", bus, model_read(io_addr));
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        io_addr = a; tb_dat = d; tb_oe = 1'b1; io_wr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk(sync_pattern == m_sync, "R11 early", sync_pattern, m_sync);
        @(posedge clk);
        #1 if (a == 8'h00) m_sync = d;
        chk(sync_pattern == m_sync, tag, sync_pattern, m_sync);
        repeat (2) @(negedge clk);
        io_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        tb_oe = 1'b0; io_addr = 8'hFF;
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        io_addr = a; io_rd_n = 1'b0;
        #1 e = model_read(a);
        chk(bus == e, tag, bus, e);
        repeat (3) @(negedge clk);
        io_rd_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 if (a == 8'h01) m_full = 0;
        @(negedge clk);
        io_addr = 8'hFF;
    endtask

    task automatic do_word(input logic [7:0] w);
        @(negedge clk);
        rx_word_vld = 1'b1; rx_word = w;
        @(posedge clk);
        #1 m_hold = w; m_full = 1;
        @(negedge clk);
        rx_word_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        do_read(8'h01, "R1 data after reset");
        do_read(8'h00, "R1 sync after reset");

        do_write(8'h00, 8'hA5, "R2 sync write");
        do_read(8'h00, "R3 sync read");
        do_read(8'h01, "R6 empty read");

        do_word(8'h3C);
        do_read(8'h01, "R4 word read");
        do_read(8'h01, "R7 cleared after read");

        do_word(8'h11);
        do_word(8'h22);
        do_read(8'h01, "R5 overwrite");

        do_word(8'h77);
        do_read(8'h00, "R7 sync read keeps full");
        do_read(8'h01, "R7 word still held");

        do_write(8'h01, 8'h99, "R10 write data addr");
        do_write(8'h02, 8'h55, "R10 write other addr");
        do_read(8'h01, "R10 data unchanged");
        do_read(8'h00, "R10 sync unchanged");

        // R9: another device owns address 02h
        @(negedge clk);
        io_addr = 8'h02; tb_dat = 8'h5A; tb_oe = 1'b1; io_rd_n = 1'b0;
        #1 chk(bus == 8'h5A, "R9 bus free", bus, 8'h5A);
        repeat (3) @(negedge clk);
        io_rd_n = 1'b1; tb_oe = 1'b0;
        repeat (4) @(negedge clk);
        io_addr = 8'hFF;

        // R8: word pulse on the edge where the read completion lands
        do_word(8'hE1);
        @(negedge clk);
        io_addr = 8'h01; io_rd_n = 1'b0;
        #1 chk(bus == 8'hE1, "R8 first read", bus, 8'hE1);
        repeat (3) @(negedge clk);
        io_rd_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rx_word_vld = 1'b1; rx_word = 8'h4B;
        @(posedge clk);
        #1 m_hold = 8'h4B; m_full = 1;
        @(negedge clk);
        rx_word_vld = 1'b0; io_addr = 8'hFF;
        do_read(8'h01, "R8 new word kept");
        do_read(8'h01, "R8 then empty");

        do_write(8'h00, 8'hC3, "R2 second write");
        do_read(8'h01, "R6 empty returns new pattern");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule